// File: doc/BRIEF.md
# Shared-Counter PWM Compare Array

This block drives four output pins from a single free-running 16-bit counter. Each pin belongs to a compare channel that can work in one of two ways. In PWM mode it compares the counter's low byte against a 9-bit duty value, so every channel runs at the same 256-count period while its duty is set on its own. In toggle mode it inverts its pin each time the full 16-bit count reaches a 16-bit compare value.

Software programs the channels through a byte-wide write port. The PWM duty is double-buffered. Software writes a shadow value, and the channel copies that shadow into its active duty only when the low byte of the counter rolls over. A duty change therefore always begins on a period boundary. The ninth duty bit lets a channel stay low for the whole period as well as high for the whole period.

Top module: `pwm_compare_array`

## Requirements
- R1: Synchronous active-high reset clears the counter and every channel register to zero and drives every output pin high.
- R2: The 16-bit counter advances by one on each clock in which `cnt_en` is high and holds its value otherwise.
- R3: A write with `wr_en` high selects the channel with `wr_addr[3:2]` and the register with `wr_addr[1:0]`: 0 = mode, 1 = low compare byte, 2 = high compare byte, 3 = extension bits. In the extension register, bit 1 is the shadow duty bit 8 and bit 0 is the active duty bit 8. Bits 7..2 are ignored.
- R4: Mode bits are bit 3 PWM enable, bit 2 toggle enable, bit 1 match enable and bit 0 compare enable. PWM runs only when bits 3 and 0 are both set. Toggle runs only when bits 2, 1 and 0 are all set and PWM is not running.
- R5: In PWM mode the pin is registered. One cycle after the counter low byte is below the active 9-bit duty {active bit 8, low compare byte}, the pin is low. One cycle after the low byte is equal to or above that duty, the pin is high.
- R6: An active duty of 100h or more keeps the pin low for the whole 256-cycle period. A duty of 0 keeps it high for the whole period.
- R7: On the enabled clock where the low byte goes from FFh to 00h, a PWM channel loads its active duty from the shadow {shadow bit 8, high compare byte}.
- R8: While PWM runs, writes to the low compare byte and to the active bit 8 are ignored. A shadow write made mid-period does not change the period in progress.
- R9: In toggle mode the pin inverts on the clock after an enabled count equals {high compare byte, low compare byte}, and at no other time.
- R10: A channel that runs neither mode holds its pin at its last value.
- R11: All channels share the period, and each channel's duty is independent of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Channel (bits 3:2) and register (bits 1:0) select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 4 | Channel output pins |

## Verification
Two cases are hard to reach from the ports. The first is a shadow write that lands in the middle of a PWM period, where it must not alter that period. The bench tracks its own copy of the counter, so it can place such a write at a chosen low-byte value and then count the high cycles over the whole period and over the one after it. The second is the pause check for toggle mode. The bench stops the counter just before a programmed match and resumes it later. The pin must then invert exactly on the model's match cycle: a counter that kept running would invert it early.

// File: rtl/pca_pkg.sv
package pca_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int DUTY_W = BYTE_W + 1;

    typedef struct packed {
        logic pwm_en;
        logic tog_en;
        logic match_en;
        logic cmp_en;
    } mode_t;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_LO   = 2'd1,
        REG_HI   = 2'd2,
        REG_EXT  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_PWM    = 2'd1,
        OP_TOGGLE = 2'd2
    } ch_op_e;

    typedef struct packed {
        mode_t             mode;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              ext_act;
        logic              ext_shd;
    } chan_regs_t;

    function automatic ch_op_e decode_op(input mode_t m);
        if (m.pwm_en && m.cmp_en)
            return OP_PWM;
        else if (m.tog_en && m.match_en && m.cmp_en)
            return OP_TOGGLE;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/pca_timebase.sv
module pca_timebase
    import pca_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt_en)
            cnt <= cnt + 1'b1;
    end

    // Low byte about to roll over on this enabled edge
    assign wrap = cnt_en && (cnt[BYTE_W-1:0] == {BYTE_W{1'b1}});

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> cnt == $past(cnt) + 1'b1); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(cnt)); // R2

endmodule

// File: rtl/pca_chan_regs.sv
module pca_chan_regs
    import pca_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] data,
    input  logic              wrap,
    output chan_regs_t        regs,
    output ch_op_e            op
);

    logic unused_data_hi;
    assign unused_data_hi = ^data[BYTE_W-1:4];

    assign op = decode_op(regs.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (we) begin
                unique case (sel)
                    REG_MODE: regs.mode <= mode_t'(data[3:0]);
                    REG_LO:   if (op != OP_PWM) regs.lo <= data;
                    REG_HI:   regs.hi <= data;
                    REG_EXT: begin
                        regs.ext_shd <= data[1];
                        if (op != OP_PWM) regs.ext_act <= data[0];
                    end
                    default: ;
                endcase
            end
            if (op == OP_PWM && wrap) begin
                regs.lo      <= regs.hi;
                regs.ext_act <= regs.ext_shd;
            end
        end
    end

    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PWM && !wrap) |=> $stable({regs.ext_act, regs.lo})); // R8
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PWM && wrap) |=> {regs.ext_act, regs.lo} == $past({regs.ext_shd, regs.hi})); // R7

endmodule

// File: rtl/pca_chan_out.sv
module pca_chan_out
    import pca_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ch_op_e            op,
    input  logic              cnt_en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [BYTE_W-1:0] cmp_lo,
    input  logic [BYTE_W-1:0] cmp_hi,
    input  logic              ext_act,
    output logic              pin
);

    logic [DUTY_W-1:0] duty;
    logic              at_or_above;
    logic              hit;

    assign duty        = {ext_act, cmp_lo};
    assign at_or_above = {1'b0, cnt[BYTE_W-1:0]} >= duty;
    assign hit         = cnt_en && (cnt == {cmp_hi, cmp_lo});

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b1;
        end else begin
            unique case (op)
                OP_PWM:    pin <= at_or_above;
                OP_TOGGLE: if (hit) pin <= ~pin;
                default:   ;
            endcase
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> $stable(pin)); // R10
    AST_FULL_OFF: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PWM && ext_act) |=> !pin); // R6
    AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PWM && !ext_act && cmp_lo == '0) |=> pin); // R6
    AST_TOGGLE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TOGGLE && hit) |=> pin != $past(pin)); // R9
    AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TOGGLE && !hit) |=> $stable(pin)); // R9

endmodule

// File: rtl/pwm_compare_array.sv
module pwm_compare_array
    import pca_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cnt_en,
    input  logic                        wr_en,
    input  logic [$clog2(NCH)+1:0]      wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    output logic [NCH-1:0]              pwm_out
);

    localparam int CH_W   = $clog2(NCH);
    localparam int ADDR_W = CH_W + 2;

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [CH_W-1:0]  ch_idx;
    reg_sel_e         reg_sel;
    logic [NCH-1:0]   ch_we;

    assign ch_idx  = wr_addr[ADDR_W-1:2];
    assign reg_sel = reg_sel_e'(wr_addr[1:0]);

    pca_timebase u_timebase (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_regs_t regs;
        ch_op_e     op;

        assign ch_we[i] = wr_en && (ch_idx == CH_W'(i));

        pca_chan_regs u_regs (
            .clk  (clk),
            .rst  (rst),
            .we   (ch_we[i]),
            .sel  (reg_sel),
            .data (wr_data),
            .wrap (wrap),
            .regs (regs),
            .op   (op)
        );

        pca_chan_out u_out (
            .clk     (clk),
            .rst     (rst),
            .op      (op),
            .cnt_en  (cnt_en),
            .cnt     (cnt),
            .cmp_lo  (regs.lo),
            .cmp_hi  (regs.hi),
            .ext_act (regs.ext_act),
            .pin     (pwm_out[i])
        );
    end

    AST_ONE_CHANNEL_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_we)); // R3
    AST_WRITE_TARGETS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $countones(ch_we) == 1); // R3

endmodule

// File: tb/pwm_compare_array_tb.sv
module pwm_compare_array_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_out;

    int checks = 0;
    int fails  = 0;
    int hc [4];
    logic [15:0] bcnt;

    always #5 clk = ~clk;

    pwm_compare_array u_dut (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    // Bench copy of the shared counter (R2)
    always @(posedge clk) begin
        if (rst) bcnt <= '0;
        else if (cnt_en) bcnt <= bcnt + 16'd1;
    end

    // {9-bit duty, expected high cycles per period}
    localparam logic [17:0] VEC [6] = '{
        {9'h000, 9'd256}, {9'h001, 9'd255}, {9'h080, 9'd128},
        {9'h0FF, 9'd1},   {9'h100, 9'd0},   {9'h1FF, 9'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic [1:0] rsel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {ch, rsel}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_lo(input logic [7:0] v);
        do @(negedge clk); while (bcnt[7:0] != v);
    endtask

    // Count high cycles per channel over one full period after a reload
    task automatic measure(input bit mid, input logic [3:0] maddr, input logic [7:0] mdata);
        for (int c = 0; c < 4; c++) hc[c] = 0;
        wait_lo(8'h80);
        wait_lo(8'h01);
        for (int k = 0; k < 256; k++) begin
            for (int c = 0; c < 4; c++) if (pwm_out[c]) hc[c]++;
            if (mid && k == 16) begin wr_en = 1'b1; wr_addr = maddr; wr_data = mdata; end
            if (mid && k == 17) wr_en = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] target;
        logic        prev;
        int          ones;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        cnt_en = 1'b1;

        // R1: pins high after reset, and held with no mode set
        ones = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_out == 4'hF) ones++;
        end
        chk(ones == 20, "R1 pins high", ones, 20);

        // R1/R4: PWM on with reset-cleared duty gives a full-on period
        for (int c = 0; c < 4; c++) wr(2'(c), 2'd0, 8'h09);
        measure(1'b0, 4'h0, 8'h00);
        for (int c = 0; c < 4; c++) chk(hc[c] == 256, "R1 zero duty", hc[c], 256);

        // R5/R6/R7: vector table walk, shadow write then reload at wrap
        for (int i = 0; i < 6; i++) begin
            logic [8:0] d;
            logic [8:0] e;
            {d, e} = VEC[i];
            wr(2'(i % 4), 2'd2, d[7:0]);
            wr(2'(i % 4), 2'd3, {6'b0, d[8], 1'b0});
            measure(1'b0, 4'h0, 8'h00);
            chk(hc[i % 4] == int'(e), "R6 R7 duty table", hc[i % 4], int'(e));
        end

        // R11: four distinct duties in the same period
        wr(2'd0, 2'd2, 8'h40); wr(2'd0, 2'd3, 8'h00);
        wr(2'd1, 2'd2, 8'h80); wr(2'd1, 2'd3, 8'h00);
        wr(2'd2, 2'd2, 8'hC0); wr(2'd2, 2'd3, 8'h00);
        wr(2'd3, 2'd2, 8'h00); wr(2'd3, 2'd3, 8'h02);
        measure(1'b0, 4'h0, 8'h00);
        chk(hc[0] == 192, "R11 ch0", hc[0], 192);
        chk(hc[1] == 128, "R11 ch1", hc[1], 128);
        chk(hc[2] == 64,  "R11 ch2", hc[2], 64);
        chk(hc[3] == 0,   "R11 ch3", hc[3], 0);

        // R5: edge placement, ch1 duty 80h
        wait_lo(8'h80);
        chk(pwm_out[1] == 1'b0, "R5 below duty", int'(pwm_out[1]), 0);
        @(negedge clk);
        chk(pwm_out[1] == 1'b1, "R5 at duty", int'(pwm_out[1]), 1);

        // R8: writes to active low byte and active bit 8 ignored in PWM
        wr(2'd1, 2'd1, 8'h10);
        wr(2'd1, 2'd3, 8'h01);
        measure(1'b0, 4'h0, 8'h00);
        chk(hc[1] == 128, "R8 active write ignored", hc[1], 128);

        // R8: mid-period shadow write leaves this period, applies to the next
        measure(1'b1, {2'd1, 2'd2}, 8'h20);
        chk(hc[1] == 128, "R8 mid-period shadow", hc[1], 128);
        measure(1'b0, 4'h0, 8'h00);
        chk(hc[1] == 224, "R7 next-period shadow", hc[1], 224);

        // R10: ch1 leaves PWM while low and holds that level
        wait_lo(8'h10);
        wr(2'd1, 2'd0, 8'h00);
        ones = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (pwm_out[1]) ones++;
        end
        chk(ones == 0, "R10 idle hold", ones, 0);

        // R4: PWM enable without compare enable does not run PWM (ch2)
        wait_lo(8'h10);
        wr(2'd2, 2'd0, 8'h08);
        ones = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (pwm_out[2]) ones++;
        end
        chk(ones == 0, "R4 pwm without compare", ones, 0);

        // R9/R2: toggle on ch3 with a counter pause before the match
        wr(2'd3, 2'd0, 8'h00);
        target = bcnt + 16'd400;
        wr(2'd3, 2'd1, target[7:0]);
        wr(2'd3, 2'd2, target[15:8]);
        wr(2'd3, 2'd0, 8'h07);
        prev = pwm_out[3];
        do @(negedge clk); while (bcnt != target - 16'd100);
        cnt_en = 1'b0;
        repeat (40) @(negedge clk);
        chk(pwm_out[3] == prev, "R2 paused no toggle", int'(pwm_out[3]), int'(prev));
        cnt_en = 1'b1;
        do @(negedge clk); while (bcnt != target);
        chk(pwm_out[3] == prev, "R2 R9 before match", int'(pwm_out[3]), int'(prev));
        @(negedge clk);
        chk(pwm_out[3] == ~prev, "R9 toggled on match", int'(pwm_out[3]), int'(~prev));

        // R4: match without toggle enable does not toggle
        wr(2'd3, 2'd0, 8'h00);
        target = bcnt + 16'd300;
        wr(2'd3, 2'd1, target[7:0]);
        wr(2'd3, 2'd2, target[15:8]);
        wr(2'd3, 2'd0, 8'h03);
        prev = pwm_out[3];
        do @(negedge clk); while (bcnt != target + 16'd2);
        chk(pwm_out[3] == prev, "R4 no toggle enable", int'(pwm_out[3]), int'(prev));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule